// File: doc/BRIEF.md
# Tree Round-Robin Request Arbiter

This block selects one winner among `N` requesters competing for a single crossbar output. It is built as a binary tree of identical two-way cells. Each cell merges the requests of its two sub-trees, passes their OR upward, and receives an enable from its parent. It forwards that enable to at most one child. Each cell stores one preference bit. The bit breaks ties between the cell's two sides and is inverted after the cell resolves a contested grant, which rotates service among competing inputs without a central pointer.

The tree's levels follow the requester index from the least significant bit upward. The root separates even-numbered inputs from odd-numbered ones, the next level separates on index bit 1, and so on down to the leaves. Under full load this ordering makes the grant sweep the inputs in plain index order.

The request/grant pair carries no payload, so there is no valid/ready handshake and no back-pressure. Requests are sampled and the grant is resolved in the same cycle. A requester keeps its request high for as long as it wants service. The preference bits update on the clock edge that closes the granted cycle.

A build-time mode chooses between two cell variants. The default, work-conserving cell hands a lone request to its side whatever the preference says. The strict-alternate cell serves only the side its preference points to. It flips on every edge where it is enabled and sees any request. This variant exists to expose the cost of pure alternation: an input that requests alone is served only once in every `N` cycles.

Top module: `tree_rr_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set, and a set bit is only ever on an input whose `req_i` bit is high in the same cycle.
- R2: In work-conserving mode, `gnt_o` is all-zero exactly when `req_i` is all-zero.
- R3: In work-conserving mode, a requester that is the only one requesting is granted in every cycle it requests, with no idle cycle between back-to-back grants.
- R4: The root cell decides between inputs with index bit 0 equal to 0 (side 0) and those with bit 0 equal to 1 (side 1). Each lower level decides on the next higher index bit. When both sides request, a preference bit of 0 selects side 0 and a bit of 1 selects side 1.
- R5: Reset clears every preference bit to 0. When all inputs request after reset, input 0 wins first.
- R6: In work-conserving mode, a cell's preference bit inverts only on a clock edge where that cell was enabled and both of its sides requested. Grants won without contest leave every preference unchanged.
- R7: With all inputs requesting continuously after reset, grants go to inputs 0, 1, …, N-1 in turn and then repeat. From any state, every input is granted at least once in any N consecutive fully loaded cycles.
- R8: Two requesters that contend at one cell and request continuously after reset alternate grants: first the side-0 input, then the side-1 input, and so on.
- R9: In strict-alternate mode (`MODE = ARB_STRICT_ALTERNATE`), a cell grants only the side its preference selects. It inverts that preference on every edge where it is enabled and either side requests. A lone continuous requester is therefore granted exactly once in every N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; preference bits update on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all preference bits |
| req_i | input | N | One request bit per input; bit i asks for the output on behalf of input i |
| gnt_o | output | N | Grant vector, one-hot or zero, resolved in the same cycle as `req_i` |

## Verification
The bench attacks the tie-break ordering. A pair such as inputs 1 and 2 must resolve to input 2 after reset, because the root splits on index parity. A tree wired on the most significant bit would pick 1 instead. It also checks that uncontested grants leave the preferences alone. A cell that flipped on every grant would move the first full-load winner away from input 0. Full-load runs must sweep inputs strictly in index order, which catches a missing or misplaced toggle at any level. Finally, a lone requester must be served every cycle in the default mode but only once per N cycles in the strict variant. This shows both a wrongly blocking work-conserving cell and a strict cell that skips its flip when it grants nothing.

// File: rtl/tree_arb_pkg.sv
package tree_arb_pkg;

  // Cell variant selected at build time.
  typedef enum logic {
    ARB_WORK_CONSERVING  = 1'b0,
    ARB_STRICT_ALTERNATE = 1'b1
  } arb_mode_e;

endpackage

// File: rtl/tree_arb_bitrev.sv
// Index permutation that reverses the bit order of the requester index.
// It is its own inverse, so the same module maps requests into tree
// order and grants back to requester order.
module tree_arb_bitrev #(
  parameter int N = 8
) (
  input  logic [N-1:0] src_i,
  output logic [N-1:0] dst_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  function automatic int rev_idx(input int v);
    int r;
    r = 0;
    for (int b = 0; b < IDX_W; b++) begin
      if (((v >> b) & 1) != 0) r = r | (1 << (IDX_W - 1 - b));
    end
    return r;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_map
    assign dst_o[i] = src_i[rev_idx(i)];
  end
endmodule

// File: rtl/tree_arb_cell.sv
// Two-way arbitration cell with a stored preference bit.
module tree_arb_cell
  import tree_arb_pkg::*;
#(
  parameter arb_mode_e MODE = ARB_WORK_CONSERVING
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_lo_i,
  input  logic req_hi_i,
  output logic gnt_lo_o,
  output logic gnt_hi_o,
  output logic req_any_o
);
  logic pref_q;
  logic take_hi;
  logic flip;

  if (MODE == ARB_WORK_CONSERVING) begin : g_wc
    // Lone side wins; preference only settles contests.
    assign take_hi = req_hi_i & (~req_lo_i | pref_q);
    assign flip    = en_i & req_lo_i & req_hi_i;
  end else begin : g_alt
    // Preference alone decides; flips whenever the cell is active.
    assign take_hi = pref_q;
    assign flip    = en_i & (req_lo_i | req_hi_i);
  end

  assign gnt_hi_o  = en_i & req_hi_i & take_hi;
  assign gnt_lo_o  = en_i & req_lo_i & ~take_hi;
  assign req_any_o = req_lo_i | req_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pref_q <= 1'b0;
    else if (flip) pref_q <= ~pref_q;
  end
endmodule

// File: rtl/tree_rr_arbiter.sv
// N-way arbiter built from N-1 two-way cells in a heap-indexed tree.
// Node 1 is the root, node k has children 2k and 2k+1, and nodes
// N..2N-1 are the leaves in bit-reversed requester order.
module tree_rr_arbiter
  import tree_arb_pkg::*;
#(
  parameter int        N    = 8,
  parameter arb_mode_e MODE = ARB_WORK_CONSERVING
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
  localparam int NODES  = 2 * N - 1;

  if (N < 2 || (1 << LEVELS) != N) begin : g_bad_n
    $error("tree_rr_arbiter: N must be a power of two of at least 2");
  end

  logic [N-1:0] req_tree;
  logic [N-1:0] gnt_tree;
  logic         node_req [1:NODES];
  logic         node_en  [1:NODES];

  tree_arb_bitrev #(.N(N)) u_req_order (
    .src_i (req_i),
    .dst_o (req_tree)
  );

  assign node_en[1] = 1'b1;

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node_req[N + j] = req_tree[j];
    assign gnt_tree[j]     = node_en[N + j];
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    tree_arb_cell #(.MODE(MODE)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (node_en[k]),
      .req_lo_i  (node_req[2 * k]),
      .req_hi_i  (node_req[2 * k + 1]),
      .gnt_lo_o  (node_en[2 * k]),
      .gnt_hi_o  (node_en[2 * k + 1]),
      .req_any_o (node_req[k])
    );
  end

  tree_arb_bitrev #(.N(N)) u_gnt_order (
    .src_i (gnt_tree),
    .dst_o (gnt_o)
  );
endmodule

// File: rtl/tree_rr_arbiter_chk.sv
module tree_rr_arbiter_chk
  import tree_arb_pkg::*;
#(
  parameter int        N    = 8,
  parameter arb_mode_e MODE = ARB_WORK_CONSERVING
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic [N-1:0] gnt_o
);
  localparam int             CW    = $clog2(N) + 1;
  localparam logic [CW-1:0]  LIMIT = CW'(N);

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o)); // R1
  AST_GNT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~req_i) == '0); // R1

  if (MODE == ARB_WORK_CONSERVING) begin : g_wc_props
    AST_WORK_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i != '0) |-> (gnt_o != '0)); // R2
    AST_LONE_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot(req_i) |-> (gnt_o == req_i)); // R3
  end

  // Consecutive fully loaded cycles each input has gone without a grant.
  for (genvar i = 0; i < N; i++) begin : g_wait
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          wait_q <= '0;
      else if (!(&req_i))   wait_q <= '0;
      else if (gnt_o[i])    wait_q <= '0;
      else                  wait_q <= wait_q + 1'b1;
    end
    AST_FULL_LOAD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) wait_q < LIMIT); // R7
  end
endmodule

bind tree_rr_arbiter tree_rr_arbiter_chk #(.N(N), .MODE(MODE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .gnt_o  (gnt_o)
);

// File: tb/sim_tree_rr_arbiter.sv
module sim_tree_rr_arbiter;
  import tree_arb_pkg::*;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_a = '0;
  logic [N-1:0] req_b = '0;
  logic [N-1:0] gnt_a;
  logic [N-1:0] gnt_b;
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tree_rr_arbiter #(.N(N), .MODE(ARB_WORK_CONSERVING)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req_a), .gnt_o (gnt_a)
  );

  tree_rr_arbiter #(.N(N), .MODE(ARB_STRICT_ALTERNATE)) u1 (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req_b), .gnt_o (gnt_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_a = '0;
    req_b = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive at the falling edge, sample before the rising edge.
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    req_a = a;
    req_b = b;
    #1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    req_a = '1;
    #1;
    chk(gnt_a != '0, "R5 grant resolves during reset", gnt_a, 8'b1);
    do_reset();
    step('0, '0);
    chk(gnt_a == '0, "R2 no request no grant", gnt_a, '0);
  endtask

  task automatic t_lone();
    do_reset();
    for (int i = 0; i < N; i++) begin
      for (int r = 0; r < 2; r++) begin
        step(N'(1) << i, '0);
        chk(gnt_a == (N'(1) << i), "R3 lone requester served each cycle", gnt_a, N'(1) << i);
      end
    end
  endtask

  task automatic t_full_load();
    do_reset();
    for (int k = 0; k < 2 * N; k++) begin
      step('1, '0);
      chk(gnt_a == (N'(1) << (k % N)), k == 0 ? "R5 first full-load winner" : "R7 index-order sweep",
          gnt_a, N'(1) << (k % N));
    end
  endtask

  task automatic t_pairs();
    logic [N-1:0] exp;
    do_reset();
    step(N'(8'b0000_0110), '0);
    chk(gnt_a == N'(8'b0000_0100), "R4 root favours even index", gnt_a, N'(8'b0000_0100));
    do_reset();
    for (int k = 0; k < 4; k++) begin
      exp = (k % 2 == 0) ? N'(8'b0000_0001) : N'(8'b0000_0010);
      step(N'(8'b0000_0011), '0);
      chk(gnt_a == exp, "R8 root-level pair alternates", gnt_a, exp);
    end
    do_reset();
    for (int k = 0; k < 4; k++) begin
      exp = (k % 2 == 0) ? N'(8'b0000_0001) : N'(8'b0001_0000);
      step(N'(8'b0001_0001), '0);
      chk(gnt_a == exp, "R8 leaf-level pair alternates", gnt_a, exp);
    end
  endtask

  task automatic t_keep_pref();
    do_reset();
    for (int k = 0; k < 3; k++) step(N'(8'b0000_0100), '0);
    for (int k = 0; k < 3; k++) step(N'(8'b1000_0000), '0);
    step('1, '0);
    chk(gnt_a == N'(1), "R6 uncontested grants keep preferences", gnt_a, N'(1));
    step('1, '0);
    chk(gnt_a == N'(2), "R6 contested grant flips root", gnt_a, N'(2));
  endtask

  task automatic t_random();
    logic [31:0] lfsr = 32'hACE1_2468;
    bit          ok1;
    bit          ok2;
    do_reset();
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[N-1:0] & lfsr[N+7:8], '0);
      ok1 = $onehot0(gnt_a) && ((gnt_a & ~req_a) == '0);
      ok2 = (gnt_a == '0) == (req_a == '0);
      chk(ok1, "R1 one-hot grant within requests", gnt_a, req_a);
      chk(ok2, "R2 work conserving", gnt_a, req_a);
    end
  endtask

  task automatic t_strict();
    int count = 0;
    int last = -1;
    bit gaps_ok = 1'b1;
    do_reset();
    for (int k = 0; k < 4 * N; k++) begin
      step('0, N'(8'b0000_1000));
      if (gnt_b == N'(8'b0000_1000)) begin
        if (last >= 0 && k - last != N) gaps_ok = 1'b0;
        last = k;
        count++;
      end else if (gnt_b != '0) begin
        gaps_ok = 1'b0;
      end
    end
    chk(count == 4, "R9 strict lone requester once per N cycles", N'(count), N'(4));
    chk(gaps_ok, "R9 strict grant spacing equals N", N'(last), N'(4 * N - 1));
  endtask

  initial begin
    t_reset_state();
    t_lone();
    t_full_load();
    t_pairs();
    t_keep_pref();
    t_random();
    t_strict();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule